// File: doc/BRIEF.md
# Dual-Predicated Vector Move Sequencer

This block expands a single compressed register-to-register move into a sequence of element copies. Each register number has an entry in a small tag table. The entry holds a vector flag and a remapped base register. When neither operand of the move is tagged, the block issues one plain copy. When either operand is tagged, the block walks a source element counter and a destination element counter independently, up to an externally supplied vector length. It issues one copy command per clock for each pair of active elements.

The source side is gated by a source predicate mask and the destination side by a destination predicate mask. Each counter skips its own masked-off elements, so a move can gather sparse source elements into dense destination slots, or scatter them the other way. A copy command names the register to read and the register to write. The register file outside the block performs the actual transfer.

A start pulse while idle launches an operation. A one-cycle done pulse ends it.

Top module: `vmove_seq`

## Requirements
- R1: The move encoding supplies the destination register in bits 11:7 and the source register in bits 6:2. Bits 15:12 and 1:0 do not affect the sequencing.
- R2: A register whose table entry has its vector flag set is replaced by the entry's base register. An untagged register is used as written. Writing a table entry with the flag clear untags that register.
- R3: Each copy reads register (source base + source counter) mod 32 and writes register (destination base + destination counter) mod 32.
- R4: When the source is tagged, the source counter skips elements whose source mask bit is 0 before each copy. When the source is untagged, the source mask is ignored and the source counter stays at 0.
- R5: When the destination is tagged, the destination counter skips elements whose destination mask bit is 0 before each copy. When the destination is untagged, the destination mask is ignored and the destination counter stays at 0.
- R6: The operation stops when a tagged side's counter reaches the vector length without finding an active element. No copy is issued for that step.
- R7: With both operands untagged and a vector length of at least 1, exactly one copy is issued. Done is asserted in the same cycle as that copy.
- R8: With a vector length of 0, done is asserted in the cycle after start and no copy is issued.
- R9: In the cycle after an accepted start, busy is high, unless the vector length is 0. Done is a single-cycle pulse with busy low. Copies of a vector operation come one per cycle.
- R10: A start pulse while busy is ignored. The running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Tag table write enable |
| tbl_addr | input | 5 | Register number whose tag entry is written |
| tbl_vec | input | 1 | Vector flag to store |
| tbl_base | input | 5 | Remapped base register to store |
| start | input | 1 | Launch a move (accepted only when idle) |
| instr | input | 16 | Compressed move encoding |
| vlen | input | 6 | Vector length, 0 to 32 |
| src_mask | input | 32 | Source predicate mask, bit k gates source element k |
| dst_mask | input | 32 | Destination predicate mask, bit k gates destination element k |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cp_valid | output | 1 | Copy command valid this cycle |
| cp_src | output | 5 | Register to read |
| cp_dst | output | 5 | Register to write |

## Verification
The assertions take for granted that vlen never exceeds 32 and that the tag table is written only while the block is idle. Under those conditions the element counters can be bounded by the latched length. The stimulus draws lengths from 0 to 32 and rewrites tag entries only between operations. Masks, operands and lengths are chosen at random around directed cases. The directed cases cover all-zero masks, address wrap past register 31, and a second start raised mid-operation.

// File: rtl/vms_pkg.sv
package vms_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} vms_state_t;

  typedef struct packed {
    logic       vec;
    logic [4:0] base;
  } vms_tag_t;
endpackage

// File: rtl/vms_tag_table.sv
module vms_tag_table #(
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wvec,
  input  logic [AW-1:0] wbase,
  input  logic [AW-1:0] ra_addr,
  output logic          ra_vec,
  output logic [AW-1:0] ra_base,
  input  logic [AW-1:0] rb_addr,
  output logic          rb_vec,
  output logic [AW-1:0] rb_base
);
  logic [NREG-1:0] vec_q;
  logic [AW-1:0]   base_mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) vec_q <= '0;
    else if (we) vec_q[waddr] <= wvec;
  end

  always_ff @(posedge clk) begin
    if (we) base_mem[waddr] <= wbase;
  end

  assign ra_vec  = vec_q[ra_addr];
  assign ra_base = base_mem[ra_addr];
  assign rb_vec  = vec_q[rb_addr];
  assign rb_base = base_mem[rb_addr];
endmodule

// File: rtl/vms_find.sv
module vms_find #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  mask,
  input  logic [CW-1:0] from,
  input  logic [CW-1:0] lim,
  output logic          found,
  output logic [CW-1:0] pos
);
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (mask[k] && (CW'(k) >= from) && (CW'(k) < lim)) begin
        found = 1'b1;
        pos   = CW'(k);
      end
    end
  end
endmodule

// File: rtl/vmove_seq.sv
module vmove_seq #(
  parameter int NREG  = 32,
  parameter int MAXVL = 32,
  localparam int AW = $clog2(NREG),
  localparam int CW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic             tbl_vec,
  input  logic [AW-1:0]    tbl_base,
  input  logic             start,
  input  logic [15:0]      instr,
  input  logic [CW-1:0]    vlen,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  output logic             busy,
  output logic             done,
  output logic             cp_valid,
  output logic [AW-1:0]    cp_src,
  output logic [AW-1:0]    cp_dst
);
  import vms_pkg::*;

  vms_state_t       state;
  logic             svec, dvec;
  logic [AW-1:0]    sbase, dbase;
  logic [MAXVL-1:0] smask, dmask;
  logic [CW-1:0]    vl_q, sctr, dctr;

  logic [AW-1:0] rs_f, rd_f;
  logic          rs_tag, rd_tag;
  logic [AW-1:0] rs_map, rd_map;

  assign rs_f = instr[2 +: AW];
  assign rd_f = instr[7 +: AW];

  vms_tag_table #(.NREG(NREG)) u_tags (
    .clk(clk), .rst(rst),
    .we(tbl_we), .waddr(tbl_addr), .wvec(tbl_vec), .wbase(tbl_base),
    .ra_addr(rs_f), .ra_vec(rs_tag), .ra_base(rs_map),
    .rb_addr(rd_f), .rb_vec(rd_tag), .rb_base(rd_map)
  );

  logic          s_found, d_found;
  logic [CW-1:0] s_pos, d_pos;

  vms_find #(.W(MAXVL), .CW(CW)) u_sfind (
    .mask(smask), .from(sctr), .lim(vl_q), .found(s_found), .pos(s_pos)
  );
  vms_find #(.W(MAXVL), .CW(CW)) u_dfind (
    .mask(dmask), .from(dctr), .lim(vl_q), .found(d_found), .pos(d_pos)
  );

  logic          s_ok, d_ok, step_ok;
  logic [CW-1:0] s_idx, d_idx;

  always_comb begin
    s_ok    = svec ? s_found : 1'b1;
    d_ok    = dvec ? d_found : 1'b1;
    s_idx   = svec ? s_pos : '0;
    d_idx   = dvec ? d_pos : '0;
    step_ok = s_ok && d_ok;
  end

  assign busy = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      cp_valid <= 1'b0;
      cp_src   <= '0;
      cp_dst   <= '0;
      svec     <= 1'b0;
      dvec     <= 1'b0;
      sbase    <= '0;
      dbase    <= '0;
      smask    <= '0;
      dmask    <= '0;
      vl_q     <= '0;
      sctr     <= '0;
      dctr     <= '0;
    end else begin
      done     <= 1'b0;
      cp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            svec  <= rs_tag;
            dvec  <= rd_tag;
            sbase <= rs_tag ? rs_map : rs_f;
            dbase <= rd_tag ? rd_map : rd_f;
            smask <= src_mask;
            dmask <= dst_mask;
            vl_q  <= vlen;
            sctr  <= '0;
            dctr  <= '0;
            if (vlen == '0) done  <= 1'b1;
            else            state <= S_RUN;
          end
        end
        S_RUN: begin
          if (step_ok) begin
            cp_valid <= 1'b1;
            cp_src   <= sbase + AW'(s_idx);
            cp_dst   <= dbase + AW'(d_idx);
            sctr     <= svec ? s_pos + CW'(1) : '0;
            dctr     <= dvec ? d_pos + CW'(1) : '0;
            if (!svec && !dvec) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vms_chk.sv
module vms_chk #(
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] vlen,
  input logic          busy,
  input logic          done,
  input logic          cp_valid,
  input logic [CW-1:0] sctr,
  input logic [CW-1:0] dctr,
  input logic [CW-1:0] vl_q
);
  a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && vlen == '0) |=> (done && !cp_valid));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_copy_from_run: assert property (@(posedge clk) disable iff (rst)
    cp_valid |-> $past(busy));

  a_r6_ctr_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (sctr <= vl_q && dctr <= vl_q));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind vmove_seq vms_chk #(.CW(CW)) u_vms_chk (
  .clk(clk), .rst(rst), .start(start), .vlen(vlen), .busy(busy),
  .done(done), .cp_valid(cp_valid), .sctr(sctr), .dctr(dctr), .vl_q(vl_q)
);

// File: tb/test_vmove_seq.sv
module test_vmove_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic        tbl_vec = 1'b0;
  logic [4:0]  tbl_base = '0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [5:0]  vlen = '0;
  logic [31:0] src_mask = '0;
  logic [31:0] dst_mask = '0;
  logic        busy, done, cp_valid;
  logic [4:0]  cp_src, cp_dst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vmove_seq i_vmove_seq (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_vec(tbl_vec), .tbl_base(tbl_base), .start(start), .instr(instr),
    .vlen(vlen), .src_mask(src_mask), .dst_mask(dst_mask), .busy(busy),
    .done(done), .cp_valid(cp_valid), .cp_src(cp_src), .cp_dst(cp_dst)
  );

  bit       m_vec [32];
  bit [4:0] m_base [32];
  int es [40];
  int ed [40];
  int ecnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_tag(input int r, input bit v, input int b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 5'(r); tbl_vec = v; tbl_base = 5'(b);
    m_vec[r] = v; m_base[r] = 5'(b);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  function automatic logic [15:0] mk(input int rd, input int rs, input logic [3:0] f4, input logic [1:0] q);
    return {f4, 5'(rd), 5'(rs), q};
  endfunction

  task automatic model(input int rd, input int rs, input int vl, input logic [31:0] sm, input logic [31:0] dm);
    bit sv = m_vec[rs];
    bit dv = m_vec[rd];
    int sb = sv ? int'(m_base[rs]) : rs;
    int db = dv ? int'(m_base[rd]) : rd;
    int ci = 0;
    int cj = 0;
    ecnt = 0;
    if (vl == 0) return;
    forever begin
      if (sv) begin
        while (ci < vl && !sm[ci]) ci++;
        if (ci >= vl) break;
      end
      if (dv) begin
        while (cj < vl && !dm[cj]) cj++;
        if (cj >= vl) break;
      end
      es[ecnt] = (sb + ci) % 32;
      ed[ecnt] = (db + cj) % 32;
      ecnt++;
      if (!sv && !dv) break;
      if (sv) ci++;
      if (dv) cj++;
      if (ci >= vl || cj >= vl) break;
    end
  endtask

  task automatic run_op(input logic [15:0] ins, input int vl, input logic [31:0] sm,
                        input logic [31:0] dm, input bit poke, input string tag);
    int got = 0;
    bit seen_done = 0;
    int gs [40];
    int gd [40];
    model(int'(ins[11:7]), int'(ins[6:2]), vl, sm, dm);
    @(negedge clk);
    instr = ins; vlen = 6'(vl); src_mask = sm; dst_mask = dm; start = 1'b1;
    for (int cyc = 0; cyc < 40 && !seen_done; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == 0) begin
        if (vl == 0) begin
          chk(done == 1'b1, {tag, " R8 done after start"}, int'(done), 1);
          chk(busy == 1'b0, {tag, " R8 no busy"}, int'(busy), 0);
        end else begin
          chk(busy == 1'b1, {tag, " R9 busy after start"}, int'(busy), 1);
        end
        if (poke && busy && !done) begin
          start = 1'b1; instr = ~ins; vlen = 6'($urandom_range(1, 32));
          src_mask = ~sm; dst_mask = ~dm;
        end
      end
      if (cp_valid && got < 40) begin
        gs[got] = int'(cp_src); gd[got] = int'(cp_dst); got++;
      end
      if (done) begin
        seen_done = 1;
        chk(busy == 1'b0, {tag, " R9 done with busy low"}, int'(busy), 0);
      end
    end
    start = 1'b0;
    chk(seen_done, {tag, " R9 done seen"}, int'(seen_done), 1);
    chk(got == ecnt, {tag, " copy count"}, got, ecnt);
    for (int k = 0; k < ecnt && k < got; k++) begin
      chk(gs[k] == es[k], {tag, " R3 copy src"}, gs[k], es[k]);
      chk(gd[k] == ed[k], {tag, " R3 copy dst"}, gd[k], ed[k]);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " R9 done single pulse"}, int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    for (int r = 0; r < 32; r++) begin m_vec[r] = 0; m_base[r] = 5'(r); end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && cp_valid == 0, "R9 reset state",
        int'({busy, done, cp_valid}), 0);

    // R1/R7: untagged pair, odd funct4 and quadrant bits
    run_op(mk(3, 7, 4'hF, 2'b01), 5, 32'h0, 32'h0, 0, "R1 R7 scalar");
    // R8: zero length
    set_tag(9, 1, 12);
    run_op(mk(9, 4, 4'h8, 2'b10), 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R8 zero");
    // R4: vector source, scalar destination, sparse source mask
    set_tag(5, 1, 8);
    run_op(mk(2, 5, 4'h8, 2'b10), 8, 32'h0000_00A5, 32'h0, 0, "R4 gather");
    // R5: vector both, dense source, sparse destination
    set_tag(6, 1, 20);
    run_op(mk(6, 5, 4'h8, 2'b10), 10, 32'h0000_03FF, 32'h0000_0242, 0, "R5 expand");
    // R6: empty source mask
    run_op(mk(6, 5, 4'h8, 2'b10), 16, 32'h0, 32'hFFFF_FFFF, 0, "R6 empty");
    // R6: active bits only beyond the length
    run_op(mk(6, 5, 4'h8, 2'b10), 4, 32'hFFFF_FF00, 32'hFFFF_FFFF, 0, "R6 beyond");
    // R3: wrap past register 31
    set_tag(11, 1, 30);
    run_op(mk(11, 5, 4'h8, 2'b10), 4, 32'hF, 32'hF, 0, "R3 wrap");
    // R10: start raised while busy
    run_op(mk(6, 5, 4'h8, 2'b10), 12, 32'h0000_0F0F, 32'h0000_0FF0, 1, "R10 poke");
    // R2: untag and reuse the number
    set_tag(5, 0, 8);
    run_op(mk(6, 5, 4'h8, 2'b10), 6, 32'h3F, 32'h15, 0, "R2 untag");

    for (int t = 0; t < 60; t++) begin
      int rd = $urandom_range(0, 31);
      int rs = $urandom_range(0, 31);
      set_tag(rd, 1'($urandom_range(0, 1)), $urandom_range(0, 31));
      set_tag(rs, 1'($urandom_range(0, 1)), $urandom_range(0, 31));
      run_op(mk(rd, rs, 4'($urandom), 2'($urandom)), $urandom_range(0, 32),
             $urandom & $urandom, $urandom | $urandom, 1'($urandom_range(0, 1)),
             "R2 R4 R5 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule